// File: doc/BRIEF.md
# Serial Synchronous Clock Generator

This block derives the bit clock of a serial port from a fast oscillator clock. A two-bit source code picks one of four rates: the oscillator divided by 4, 8 or 16, or the underflow of a small built-in reload timer divided by 2. The picked source then always passes through a final divide-by-16 stage, and the result is the synchronous bit clock. All division is done with single-cycle enable pulses in the oscillator clock domain, so no derived clock ever leaves the block.

The design has two outputs. `bit_tick` is a one-cycle strobe that marks each bit boundary. `sclk_out` is a level with 50% duty cycle. In slave mode the source code and every divider are bypassed: the external serial clock input is forwarded unchanged to `sclk_out`, and each rising edge of that input yields one `bit_tick`. The timer has a prescaler and a reload down-counter, and only its underflow sets the rate. Any change to the source code, the prescaler code or the reload value restarts the division chain, so the first bit period after a change has its full length.

Top module: `sgen_serclk`

## Requirements
- R1: With `src_sel` = 2'b10, 2'b01 or 2'b00, the master `bit_tick` period is 64, 128 or 256 oscillator cycles respectively (oscillator /4, /8, /16, each followed by /16).
- R2: While `rst_n` is low, `bit_tick` and `sclk_out` are 0 and the effective source is oscillator/16. After release with `en` high and `src_sel` = 2'b00, the first tick comes 256 cycles later.
- R3: With `src_sel` = 2'b11, the timer ticks once every D oscillator cycles, where `tmr_presc` codes 0, 1, 2, 3 give D = 1, 2, 8, 32. The timer underflows every (`tmr_reload`+1) ticks, and the bit period is 16·2·(`tmr_reload`+1)·D cycles.
- R4: After any change of `src_sel`, `tmr_presc` or `tmr_reload`, the first `bit_tick` arrives exactly one full bit period (16·P cycles, where P is the new source period) after the change.
- R5: In master mode `sclk_out` is high for exactly half of each bit period and is low in the cycle after each `bit_tick`.
- R6: With `slave_mode` high, `sclk_out` equals `ext_sclk` in every cycle, whatever the value of `src_sel`.
- R7: With `slave_mode` high, each rising edge of `ext_sclk` gives exactly one `bit_tick`, in the cycle after the edge is first sampled. A falling edge or a steady level gives none.
- R8: While `en` is low, `bit_tick` stays 0 and the master `sclk_out` stays 0. When `en` rises, the first tick comes one full bit period later.
- R9: In master mode, `bit_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; while low, all counters are held clear |
| slave_mode | input | 1 | 1 = forward the external serial clock |
| src_sel | input | 2 | Source code: 11 timer, 10 osc/4, 01 osc/8, 00 osc/16 |
| tmr_presc | input | 2 | Timer prescaler code: 0..3 gives /1, /2, /8, /32 |
| tmr_reload | input | RLD_W | Timer reload value |
| ext_sclk | input | 1 | External serial clock (used in slave mode) |
| bit_tick | output | 1 | One-cycle strobe at each bit boundary |
| sclk_out | output | 1 | Serial clock level |

## Verification
The assertions assume that the configuration inputs change only between clock edges. They also assume that `ext_sclk` is already synchronous to `clk`: it is sampled through two flops as a plain level, with no metastability handling. The timer bound check also takes for granted that a reload value differing from the stored copy always restarts the chain. The bench keeps within these limits by driving every input at the falling clock edge. It either restarts the chain with an explicit enable pulse or changes one configuration field at a time in a running chain, and then times each tick from that point.

// File: rtl/sgen_pkg.sv
// Shared types and helpers for the serial clock generator.
// Assumes: two-bit source code and two-bit prescaler code.
package sgen_pkg;

    typedef enum logic [1:0] {
        SRC_OSC16 = 2'b00,
        SRC_OSC8  = 2'b01,
        SRC_OSC4  = 2'b10,
        SRC_TIMER = 2'b11
    } src_sel_e;

    localparam int unsigned PRESC_W = 5;

    // Last prescaler count value for a code: /1, /2, /8, /32.
    function automatic logic [PRESC_W-1:0] presc_last(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd0;
            2'd1:    return 5'd1;
            2'd2:    return 5'd7;
            default: return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/sgen_tap_div.sv
// Free-running binary counter that yields single-cycle enable pulses
// at the oscillator divided by 4, 8, 16 (tap i divides by 2^(i+2)).
// Assumes: clear is held whenever the chain must restart.
module sgen_tap_div #(
    parameter int unsigned NTAP = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    output logic [NTAP-1:0] taps
);
    localparam int unsigned CW = NTAP + 1;

    logic [CW-1:0] cnt;

    // Count oscillator cycles since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        // Tap i fires when its low i+2 bits are all ones.
        assign taps[i] = &cnt[i+1:0];

        assert_tap_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
            taps[i] |=> !taps[i]);
    end

endmodule

// File: rtl/sgen_reload_timer.sv
// Prescaled reload down-counter. It loads the reload value on clear,
// decrements once per prescaled tick and emits a one-cycle underflow
// pulse when it is at zero on a tick, reloading in the same step.
// Period = (reload+1) * prescale divide.
// Assumes: reload changes only together with clear.
module sgen_reload_timer
    import sgen_pkg::*;
#(
    parameter int unsigned RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [1:0]       presc_code,
    input  logic [RLD_W-1:0] reload,
    output logic             underflow
);
    logic [PRESC_W-1:0] pc;
    logic [RLD_W-1:0]   cnt;
    logic               ptick;

    assign ptick = (pc == presc_last(presc_code));

    // Prescaler: wrap at the coded limit, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              pc <= '0;
        else if (clear || ptick) pc <= '0;
        else                     pc <= pc + 1'b1;
    end

    // Down-counter: load on clear, reload on underflow, else decrement per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= reload;
        else if (ptick)  cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end

    assign underflow = ptick && (cnt == '0) && !clear;

    assert_cnt_within_reload_R3: assert property (@(posedge clk) disable iff (!rst_n || clear)
        cnt <= reload);

endmodule

// File: rtl/sgen_bit_div.sv
// Source selector with the timer halving stage and the common
// divide-by-16 bit stage. Emits the bit strobe and a 50% duty level.
// Assumes: taps[0..2] are the /4, /8, /16 oscillator pulses.
module sgen_bit_div
    import sgen_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  src_sel_e sel,
    input  logic [2:0] taps,
    input  logic     underflow,
    output logic     tick,
    output logic     level
);
    logic                half;
    logic                src_pulse;
    logic [DIV_LOG2-1:0] dcnt;

    // Halve the timer underflow rate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) half <= 1'b0;
        else if (underflow)  half <= ~half;
    end

    // Pick the source enable pulse.
    always_comb begin
        case (sel)
            SRC_OSC4:  src_pulse = taps[0];
            SRC_OSC8:  src_pulse = taps[1];
            SRC_OSC16: src_pulse = taps[2];
            default:   src_pulse = underflow && half;
        endcase
    end

    // Common bit divider counting source pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) dcnt <= '0;
        else if (src_pulse)  dcnt <= dcnt + 1'b1;
    end

    assign tick  = src_pulse && (&dcnt) && !clear;
    assign level = dcnt[DIV_LOG2-1];

    assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_level_low_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !level);

endmodule

// File: rtl/sgen_serclk.sv
// Serial synchronous clock generator top. Holds the configuration copy
// whose mismatch restarts the chain, instances the tap divider, the
// reload timer and the bit divider, and adds the slave-mode bypass.
// Assumes: ext_sclk is synchronous to clk; inputs change between edges.
module sgen_serclk
    import sgen_pkg::*;
#(
    parameter int unsigned RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             slave_mode,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       tmr_presc,
    input  logic [RLD_W-1:0] tmr_reload,
    input  logic             ext_sclk,
    output logic             bit_tick,
    output logic             sclk_out
);
    localparam int unsigned NTAP = 3;

    logic             en_q;
    src_sel_e         sel_q;
    logic [1:0]       presc_q;
    logic [RLD_W-1:0] rld_q;
    logic             restart;
    logic [NTAP-1:0]  taps;
    logic             uf;
    logic             mst_tick;
    logic             mst_level;
    logic             ext_q1;
    logic             ext_q2;
    logic             slv_tick;

    // Configuration copy; reset selects oscillator/16.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            sel_q   <= SRC_OSC16;
            presc_q <= 2'd0;
            rld_q   <= '0;
        end else begin
            en_q    <= en;
            sel_q   <= src_sel_e'(src_sel);
            presc_q <= tmr_presc;
            rld_q   <= tmr_reload;
        end
    end

    assign restart = !en_q || (src_sel != sel_q) || (tmr_presc != presc_q)
                   || (tmr_reload != rld_q);

    sgen_tap_div #(.NTAP(NTAP)) u_taps (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .taps  (taps)
    );

    sgen_reload_timer #(.RLD_W(RLD_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .presc_code (presc_q),
        .reload     (tmr_reload),
        .underflow  (uf)
    );

    sgen_bit_div #(.DIV_LOG2(4)) u_bitdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .sel       (sel_q),
        .taps      (taps),
        .underflow (uf),
        .tick      (mst_tick),
        .level     (mst_level)
    );

    // Two-stage sample of the external clock for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q1 <= 1'b0;
            ext_q2 <= 1'b0;
        end else begin
            ext_q1 <= ext_sclk;
            ext_q2 <= ext_q1;
        end
    end

    assign slv_tick = ext_q1 && !ext_q2;

    assign bit_tick = en_q && (slave_mode ? slv_tick : mst_tick);
    assign sclk_out = slave_mode ? ext_sclk : (en_q && mst_level);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bit_tick);

    assert_slave_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && slv_tick) |=> !slv_tick);

endmodule

// File: tb/test_sgen_serclk.sv
module test_sgen_serclk;
    localparam int RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          slave = 1'b0;
    logic          ext = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic [1:0]    presc = 2'b00;
    logic [RW-1:0] rld = '0;
    logic          bit_tick;
    logic          sclk_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sgen_serclk #(.RLD_W(RW)) i_sgen_serclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .slave_mode (slave),
        .src_sel    (sel),
        .tmr_presc  (presc),
        .tmr_reload (rld),
        .ext_sclk   (ext),
        .bit_tick   (bit_tick),
        .sclk_out   (sclk_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until bit_tick is seen.
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 40000);
    endtask

    // First tick after a restart, then one full period with duty count.
    task automatic run_period(input string req, input int p);
        int n;
        int m;
        int hi;
        wait_tick(n);
        check(n == 16 * p, req, n, 16 * p);
        m = 0;
        hi = 0;
        do begin
            @(negedge clk);
            m++;
            if (sclk_out) hi++;
        end while (!bit_tick && m < 40000);
        check(m == 16 * p, {req, "/R9 period"}, m, 16 * p);
        check(hi == 8 * p, "R5 duty", hi, 8 * p);
    endtask

    // Restart through an enable pulse with a new configuration.
    task automatic start(input logic [1:0] s, input logic [1:0] pc, input int r);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        sel = s;
        presc = pc;
        rld = RW'(r);
    endtask

    initial begin
        int divs[4];
        int rls[4];
        int bad;
        int n;
        divs = '{1, 2, 8, 32};
        rls  = '{0, 1, 3, 7};

        // R2: reset state
        repeat (5) @(negedge clk);
        check(bit_tick == 1'b0, "R2 tick in reset", int'(bit_tick), 0);
        check(sclk_out == 1'b0, "R2 sclk in reset", int'(sclk_out), 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(bit_tick == 1'b0 && sclk_out == 1'b0, "R2 en ignored in reset",
              int'(bit_tick) + int'(sclk_out), 0);
        rst_n = 1'b1;
        run_period("R2 default osc/16", 16);

        // R1: oscillator taps
        for (int s = 2; s >= 0; s--) begin
            start(2'(s), 2'd0, 0);
            run_period("R1", (s == 2) ? 4 : (s == 1) ? 8 : 16);
        end

        // R3: timer source sweep over prescaler and reload
        for (int pc = 0; pc < 4; pc++) begin
            for (int k = 0; k < 4; k++) begin
                start(2'b11, 2'(pc), rls[k]);
                run_period("R3", 2 * (rls[k] + 1) * divs[pc]);
            end
        end

        // R4: select change mid-period
        start(2'b10, 2'd0, 0);
        repeat (100) @(negedge clk);
        sel = 2'b01;
        run_period("R4 select change", 8);
        // R4: reload change mid-period
        start(2'b11, 2'd0, 3);
        repeat (37) @(negedge clk);
        rld = RW'(5);
        run_period("R4 reload change", 12);
        // R4: prescaler change mid-period
        repeat (21) @(negedge clk);
        presc = 2'd1;
        run_period("R4 prescaler change", 24);

        // R8: enable low holds everything quiet
        start(2'b10, 2'd0, 0);
        repeat (30) @(negedge clk);
        en = 1'b0;
        bad = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (bit_tick || sclk_out) bad++;
        end
        check(bad == 0, "R8 quiet while disabled", bad, 0);
        en = 1'b1;
        run_period("R8 first after enable", 4);

        // R6: slave pass-through regardless of select
        slave = 1'b1;
        bad = 0;
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                ext = ((8'hB4 >> (i % 8)) & 1) != 0;
                #1;
                if (sclk_out != ext) bad++;
            end
        end
        check(bad == 0, "R6 pass-through", bad, 0);

        // R7: slave edge strobe
        @(negedge clk);
        ext = 1'b0;
        repeat (4) @(negedge clk);
        check(bit_tick == 1'b0, "R7 no tick when low", int'(bit_tick), 0);
        ext = 1'b1;
        @(negedge clk);
        check(bit_tick == 1'b1, "R7 tick after rise", int'(bit_tick), 1);
        @(negedge clk);
        check(bit_tick == 1'b0, "R7 single tick", int'(bit_tick), 0);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bit_tick) bad++;
        end
        check(bad == 0, "R7 steady high", bad, 0);
        ext = 1'b0;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bit_tick) n++;
        end
        check(n == 0, "R7 falling edge", n, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog (all requirements): actual %0d expected %0d", 190000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule